// File: doc/BRIEF.md
# Sector Page Load and Program Sequencer

This block sits behind the command decoder of a byte-wide flash model. The decoder raises a program-enable once its unlock sequence has been seen. The next write pulse then opens a load window. That first write also fixes which sector is targeted, and every accepted write deposits one byte into a page latch that holds a whole sector. No explicit commit command exists. The window closes when a set number of clock cycles passes without an accepted write.

When the window closes, the block raises a busy flag and runs a timed internal cycle on a behavioural memory array. The first pass wipes every byte of the target sector. The second pass writes each latched byte back, and any byte position that received no load gets a fixed fill pattern. The last accepted address and data byte are held on outputs so that status logic can report them. A synchronous read port returns array contents.

Two boot regions, one at each end of the array, can each be locked. A window aimed at a locked region never opens. The defaults give an 11-bit address, 128-byte sectors and 512-byte boot regions. A full-size array sets `ADDR_W` to 17 and `BOOT_AW` to 13.

Top module: `sector_prog_seq`

## Requirements
- R1: After reset, `busy`, `last_addr` and `last_data` are all zero.
- R2: When the block is idle, a write pulse opens a load window only if `prog_en` is high. A write pulse with `prog_en` low changes nothing.
- R3: The first write of a window fixes the sector, taken from address bits `[ADDR_W-1:7]`. A later write that names any other sector is ignored: status is not updated and the timeout is not restarted.
- R4: Bytes are accepted in any order, with the byte position taken from address bits `[6:0]`. Every accepted write updates `last_addr` and `last_data` on the next clock edge.
- R5: A write is accepted if it comes no more than `LOAD_TIMEOUT` cycles after the previous accepted write. If no write is accepted for `LOAD_TIMEOUT` edges, `busy` rises on that edge.
- R6: `busy` stays high for exactly `PROG_CYCLES` cycles and falls on the following edge.
- R7: After the cycle, every loaded byte position reads back its data. Every other byte of that sector reads the fill value 8'hFF, whatever it held before.
- R8: Write pulses are ignored while `busy` is high.
- R9: With `lock_lo` high, no window opens for a sector in the lowest `2**BOOT_AW` bytes. With `lock_hi` high, the same applies to the highest `2**BOOT_AW` bytes. Each flag affects only its own region.
- R10: `rd_data` shows the array byte at `rd_addr` one clock edge after `rd_addr` is applied.
- R11: If the same byte position is loaded more than once in a window, the last value loaded is the one programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle byte write pulse |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Byte value of the write |
| prog_en | input | 1 | Unlock indication from the command decoder |
| lock_lo | input | 1 | Lock for the low boot region |
| lock_hi | input | 1 | Lock for the high boot region |
| rd_addr | input | ADDR_W | Read address |
| busy | output | 1 | Internal erase/program cycle in progress |
| last_addr | output | ADDR_W | Address of the last accepted write |
| last_data | output | DATA_W | Data of the last accepted write |
| rd_data | output | DATA_W | Array byte at the previous `rd_addr` |

## Verification
The checker watches several properties on every cycle. It counts `busy` cycles to hold the cycle length to `PROG_CYCLES`. It requires the reported status to stay frozen while busy and the sector to stay fixed within a window. It requires `busy` to rise only out of a window, and it refuses any window that opens on a locked region.

Other behaviours can only be shown by the bench's scenarios, because they depend on array contents: that bytes land where they were loaded, that unloaded positions and stale data become fill, that the last write to a repeated byte position is the one kept, and that ignored writes leave the memory untouched. The exact edge on which the timeout fires, including a write accepted on the last allowed cycle, is also left to the bench.

// File: rtl/sp_pkg.sv
package sp_pkg;
    typedef enum logic [1:0] {
        SP_IDLE  = 2'd0,
        SP_LOAD  = 2'd1,
        SP_CYCLE = 2'd2
    } sp_state_e;
endpackage

// File: rtl/sp_span_counter.sv
module sp_span_counter #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/sp_page_latch.sv
module sp_page_latch #(
    parameter int IDX_W  = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    localparam int SLOTS = 1 << IDX_W;

    logic [DATA_W-1:0] data_q [SLOTS];
    logic [SLOTS-1:0]  valid_q;

    // one valid bit per slot: clear opens a fresh window, a write marks its slot
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic hit;
        assign hit = we && (widx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) valid_q[i] <= 1'b0;
            else        valid_q[i] <= (clr ? 1'b0 : valid_q[i]) | hit;
        end

        always_ff @(posedge clk) begin
            if (hit) data_q[i] <= wdata;
        end
    end

    assign rdata  = data_q[ridx];
    assign rvalid = valid_q[ridx];
endmodule

// File: rtl/sp_mem_array.sv
module sp_mem_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];
    logic [DATA_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
        rd_q <= cells[raddr];
    end

    assign rdata = rd_q;
endmodule

// File: rtl/sector_prog_seq.sv
module sector_prog_seq
    import sp_pkg::*;
#(
    parameter int              ADDR_W       = 11,
    parameter int              DATA_W       = 8,
    parameter int              SECT_AW      = 7,
    parameter int              BOOT_AW      = 9,
    parameter int              LOAD_TIMEOUT = 16,
    parameter int              PROG_CYCLES  = 300,
    parameter logic [DATA_W-1:0] FILL       = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              prog_en,
    input  logic              lock_lo,
    input  logic              lock_hi,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic [ADDR_W-1:0] last_addr,
    output logic [DATA_W-1:0] last_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int SECT_BYTES = 1 << SECT_AW;
    localparam int SEC_W      = ADDR_W - SECT_AW;
    localparam int NUM_SECT   = 1 << SEC_W;
    localparam int BOOT_SECT  = 1 << (BOOT_AW - SECT_AW);
    localparam int CNT_MAX    = (PROG_CYCLES > LOAD_TIMEOUT) ? PROG_CYCLES : LOAD_TIMEOUT;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);

    typedef struct packed {
        sp_state_e         st;
        logic [SEC_W-1:0]  sec;
        logic [ADDR_W-1:0] la;
        logic [DATA_W-1:0] ld;
    } regs_t;

    regs_t regs_q, regs_d;

    logic [CNT_W-1:0]   cnt;
    logic               cnt_clr, cnt_inc;
    logic [SEC_W-1:0]   sec_in;
    logic [SECT_AW-1:0] idx_in;
    logic               locked_in;
    logic               in_window;
    logic               open_win, take, accept, timeout, done;
    logic               erase_ph, prog_ph;
    logic [SECT_AW-1:0] walk_idx;
    logic [DATA_W-1:0]  lat_data;
    logic               lat_valid;
    logic               mem_we;
    logic [DATA_W-1:0]  mem_wdata;

    assign sec_in    = wr_addr[ADDR_W-1:SECT_AW];
    assign idx_in    = wr_addr[SECT_AW-1:0];
    assign locked_in = (lock_lo && (sec_in < SEC_W'(BOOT_SECT)))
                    || (lock_hi && (sec_in >= SEC_W'(NUM_SECT - BOOT_SECT)));
    assign in_window = (regs_q.st == SP_LOAD);

    always_comb begin
        open_win = (regs_q.st == SP_IDLE) && wr_stb && prog_en && !locked_in;
        take     = in_window && wr_stb && (sec_in == regs_q.sec);
        accept   = open_win || take;
        timeout  = in_window && !take && (cnt == CNT_W'(LOAD_TIMEOUT - 1));
        done     = (regs_q.st == SP_CYCLE) && (cnt == CNT_W'(PROG_CYCLES - 1));

        regs_d = regs_q;
        if (accept) begin
            regs_d.la = wr_addr;
            regs_d.ld = wr_data;
        end
        if (open_win) begin
            regs_d.st  = SP_LOAD;
            regs_d.sec = sec_in;
        end
        if (timeout) regs_d.st = SP_CYCLE;
        if (done)    regs_d.st = SP_IDLE;

        cnt_clr = accept || timeout || done;
        cnt_inc = (regs_q.st != SP_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // cycle walk: first pass wipes the sector, second pass writes latch or fill
    assign erase_ph  = (regs_q.st == SP_CYCLE) && (cnt < CNT_W'(SECT_BYTES));
    assign prog_ph   = (regs_q.st == SP_CYCLE) && (cnt >= CNT_W'(SECT_BYTES))
                    && (cnt < CNT_W'(2 * SECT_BYTES));
    assign walk_idx  = cnt[SECT_AW-1:0];
    assign mem_we    = erase_ph || prog_ph;
    assign mem_wdata = (prog_ph && lat_valid) ? lat_data : FILL;

    sp_span_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (cnt)
    );

    sp_page_latch #(.IDX_W(SECT_AW), .DATA_W(DATA_W)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (open_win),
        .we     (accept),
        .widx   (idx_in),
        .wdata  (wr_data),
        .ridx   (walk_idx),
        .rdata  (lat_data),
        .rvalid (lat_valid)
    );

    sp_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr ({regs_q.sec, walk_idx}),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    assign busy      = (regs_q.st == SP_CYCLE);
    assign last_addr = regs_q.la;
    assign last_data = regs_q.ld;
endmodule

// File: rtl/sp_seq_checker.sv
module sp_seq_checker #(
    parameter int ADDR_W      = 11,
    parameter int SECT_AW     = 7,
    parameter int BOOT_AW     = 9,
    parameter int PROG_CYCLES = 300
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              in_load,
    input logic              lock_lo,
    input logic              lock_hi,
    input logic [ADDR_W-1:0] last_addr
);
    localparam int SEC_W     = ADDR_W - SECT_AW;
    localparam int NUM_SECT  = 1 << SEC_W;
    localparam int BOOT_SECT = 1 << (BOOT_AW - SECT_AW);
    localparam int BW        = $clog2(PROG_CYCLES + 1);

    logic [BW-1:0]    bcnt_q;
    logic [SEC_W-1:0] cur_sec;

    always_ff @(posedge clk) begin
        if (!rst_n)    bcnt_q <= '0;
        else if (busy) bcnt_q <= bcnt_q + BW'(1);
        else           bcnt_q <= '0;
    end

    assign cur_sec = last_addr[ADDR_W-1:SECT_AW];

    a_r6_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bcnt_q < BW'(PROG_CYCLES)));

    a_r6_busy_release: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bcnt_q == BW'(PROG_CYCLES - 1)) |=> !busy);

    a_r8_status_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(last_addr)));

    a_r3_sector_held: assert property (@(posedge clk) disable iff (!rst_n)
        (in_load && $past(in_load)) |-> (cur_sec == $past(cur_sec)));

    a_r5_cycle_from_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(in_load));

    a_r9_lock_respected: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_load) |->
            !(($past(lock_lo) && (cur_sec < SEC_W'(BOOT_SECT)))
           || ($past(lock_hi) && (cur_sec >= SEC_W'(NUM_SECT - BOOT_SECT)))));
endmodule

bind sector_prog_seq sp_seq_checker #(
    .ADDR_W      (ADDR_W),
    .SECT_AW     (SECT_AW),
    .BOOT_AW     (BOOT_AW),
    .PROG_CYCLES (PROG_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .in_load   (in_window),
    .lock_lo   (lock_lo),
    .lock_hi   (lock_hi),
    .last_addr (last_addr)
);

// File: tb/sector_prog_seq_test.sv
module sector_prog_seq_test;
    localparam int AW     = 11;
    localparam int LOAD_T = 16;
    localparam int PROG_C = 300;

    // {gap cycles before load, byte index, data}, all in sector 5
    localparam logic [23:0] VEC [8] = '{
        24'h00_09_A1, 24'h03_02_B2, 24'h00_78_C3, 24'h0F_40_D4,
        24'h01_00_00, 24'h00_7F_E5, 24'h05_09_7E, 24'h02_21_3C
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_stb = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          prog_en = 1'b1;
    logic          lock_lo = 1'b0;
    logic          lock_hi = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          busy;
    logic [AW-1:0] last_addr;
    logic [7:0]    last_data;
    logic [7:0]    rd_data;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    sector_prog_seq uut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .prog_en(prog_en), .lock_lo(lock_lo),
        .lock_hi(lock_hi), .rd_addr(rd_addr), .busy(busy),
        .last_addr(last_addr), .last_data(last_data), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic load(input logic [AW-1:0] a, input logic [7:0] d);
        wr_stb  = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        rd_addr = a;
        @(negedge clk);
        d = rd_data;
    endtask

    task automatic finish_cycle();
        repeat (LOAD_T + PROG_C + 2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] exp_b [128];
        for (int i = 0; i < 128; i++) exp_b[i] = 8'hFF;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 last_addr", last_addr, 0);
        chk("R1 last_data", last_data, 0);

        // R2: write with prog_en low is ignored
        prog_en = 1'b0;
        load(11'h280, 8'h55);
        repeat (LOAD_T + 3) @(negedge clk);
        chk("R2 no window busy", busy, 0);
        chk("R2 no status", last_addr, 0);
        prog_en = 1'b1;

        // R4 R5 R11: table-driven window in sector 5, gaps up to LOAD_T-1
        for (int k = 0; k < 8; k++) begin
            repeat (int'(VEC[k][23:16])) @(negedge clk);
            load(11'h280 | AW'(VEC[k][15:8]), VEC[k][7:0]);
            exp_b[VEC[k][15:8]] = VEC[k][7:0];
            chk("R4 last_addr", last_addr, 11'h280 | AW'(VEC[k][15:8]));
            chk("R4 last_data", last_data, VEC[k][7:0]);
            chk("R5 still loading", busy, 0);
        end
        repeat (LOAD_T - 1) @(negedge clk);
        chk("R5 busy before timeout", busy, 0);
        @(negedge clk);
        chk("R5 busy at timeout", busy, 1);
        repeat (PROG_C - 1) @(negedge clk);
        chk("R6 busy last cycle", busy, 1);
        @(negedge clk);
        chk("R6 busy released", busy, 0);

        // R7 R10 R11: read back full sector
        for (int i = 0; i < 128; i++) begin
            rd(11'h280 | AW'(i), v);
            chk("R7 R10 sector readback", v, exp_b[i]);
        end

        // R7: reprogram with one byte, old contents become fill
        load(11'h280, 8'h99);
        finish_cycle();
        rd(11'h280, v);  chk("R7 reloaded byte", v, 8'h99);
        rd(11'h289, v);  chk("R7 stale byte filled", v, 8'hFF);

        // R3: off-sector write ignored
        load(11'h303, 8'h11);
        load(11'h384, 8'h22);
        chk("R3 off-sector status", last_addr, 11'h303);
        chk("R3 off-sector data", last_data, 8'h11);
        finish_cycle();
        rd(11'h303, v);  chk("R3 own byte", v, 8'h11);
        rd(11'h304, v);  chk("R3 foreign byte not loaded", v, 8'hFF);

        // R8: writes during busy ignored
        load(11'h405, 8'h12);
        repeat (LOAD_T + 3) @(negedge clk);
        chk("R8 in cycle", busy, 1);
        load(11'h406, 8'h34);
        load(11'h480, 8'h56);
        chk("R8 status frozen", last_addr, 11'h405);
        repeat (PROG_C) @(negedge clk);
        chk("R8 done", busy, 0);
        rd(11'h406, v);  chk("R8 write dropped", v, 8'hFF);
        rd(11'h405, v);  chk("R8 kept byte", v, 8'h12);

        // R9: boot region locks
        load(11'h080, 8'h5A);
        finish_cycle();
        load(11'h700, 8'h66);
        finish_cycle();
        lock_lo = 1'b1;
        load(11'h080, 8'h00);
        repeat (LOAD_T + 3) @(negedge clk);
        chk("R9 low lock no busy", busy, 0);
        chk("R9 low lock status", last_addr, 11'h700);
        rd(11'h080, v);  chk("R9 low region intact", v, 8'h5A);
        load(11'h701, 8'h77);
        finish_cycle();
        rd(11'h701, v);  chk("R9 high free under low lock", v, 8'h77);
        lock_lo = 1'b0;
        lock_hi = 1'b1;
        load(11'h701, 8'h01);
        repeat (LOAD_T + 3) @(negedge clk);
        chk("R9 high lock no busy", busy, 0);
        rd(11'h701, v);  chk("R9 high region intact", v, 8'h77);
        load(11'h081, 8'h3E);
        finish_cycle();
        rd(11'h081, v);  chk("R9 low free under high lock", v, 8'h3E);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule